// File: doc/BRIEF.md
# Programmable PWM Sequencer Channel

This block is a single PWM output whose duty level is produced by a short stored program, not by a fixed compare value. A host fills a 64-word program store. Each 16-bit word arrives as a pair of bytes on a byte-wide write port. When the channel enable input is raised, a sequencer steps through the words. Each word can do one of the following:

- force the pin permanently low or permanently high;
- load a level directly;
- ramp the level up or down one count at a time at a programmed pace;
- send execution back to the first word.

An 8-bit counter advances on every pulse of the slow tick input, which nominally runs at 32768 Hz, and wraps freely. The pin is high while the level is at or above that counter.

The host is expected to work in this order: lower the enable, write the program bytes, then raise the enable again. Lowering the enable stops execution and parks the pin low. The level is kept. The next run starts again from the first word.

Top module: `pwm_seq_chan`

## Requirements
- R1: While `chanEn` is low, each `wrValid` byte is taken in order: first the upper byte, then the lower byte of a word. Each completed word is stored at the next program address, starting from address 0. At most 64 words are kept. The program length becomes the number of words written in the current load. While `chanEn` is high, write bytes are ignored.
- R2: When `chanEn` is low, the following hold:
  - `pwmOut` is low one cycle later;
  - the level is kept;
  - execution restarts at address 0 on the next enable;
  - any forced state is cleared;
  - a falling edge of `chanEn` returns the write address and the byte phase to their start.
- R3: An 8-bit counter increments on every `tickIn` pulse and wraps from 255 to 0. While the channel runs unforced, `pwmOut` is registered and equals (level >= counter) one clock after the counter changes.
- R4: Word 0x007F forces `pwmOut` low and stops execution. Word 0x00FF forces `pwmOut` high and stops execution. Both states last until the channel is disabled.
- R5: Word 0x0000 sends execution back to address 0. So does any word with bits 15 and 13 both set.
- R6: With `LOAD_EN` set, a word with bit 14 set, bit 15 clear and bits 13:8 all zero writes its low byte into the level.
- R7: Any other word is a ramp. Bit 7 gives the direction (0 = up, 1 = down) and bits 6:0 give the number of steps. Each step changes the level by one. The level stops at 0 and 255 instead of wrapping. A step count of 0 moves straight to the next word.
- R8: Bits 13:8 of a ramp give the step time, with 0 read as 1. Bit 14 selects the divider. One step takes step_time × 16 tick pulses when bit 14 is clear, and step_time × 512 tick pulses when bit 14 is set.
- R9: When execution passes the last stored word, it continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chanEn | input | 1 | Channel run enable |
| tickIn | input | 1 | One-cycle pulse of the slow PWM tick |
| wrValid | input | 1 | Program byte valid |
| wrByte | input | 8 | Program byte, upper half of a word first |
| pwmOut | output | 1 | PWM output pin |
| levelOut | output | 8 | Current duty level |

## Verification
The assertions take for granted that:

- `tickIn` is a clean one-cycle pulse;
- a level step can only follow such a pulse;
- program bytes are only offered while the channel is stopped, so the write address cannot move during a run.

The bench keeps to these assumptions. It raises `tickIn` for exactly one clock, separated by an idle clock. It drops the enable before every program load. The one deliberate write during a run is there to show that it is ignored.

// File: rtl/pwm_seq_pkg.sv
`timescale 1ns/1ps
package pwm_seq_pkg;
  localparam int LVL_W  = 8;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    K_GOTO, K_OFF, K_ON, K_LOAD, K_RAMP
  } instrKind_t;

  typedef struct packed {
    logic             levelLoad;
    logic [LVL_W-1:0] loadVal;
    logic             stepUp;
    logic             stepDn;
    logic             forceOff;
    logic             forceOn;
    logic             forceClr;
  } ctlStb_t;

  function automatic instrKind_t classify(input logic [WORD_W-1:0] w, input logic loadEn);
    if (w == 16'h0000)                                     return K_GOTO;
    else if (w == 16'h007F)                                return K_OFF;
    else if (w == 16'h00FF)                                return K_ON;
    else if (w[15] && w[13])                               return K_GOTO;
    else if (loadEn && w[14] && !w[15] && w[13:8] == '0)   return K_LOAD;
    else                                                   return K_RAMP;
  endfunction
endpackage

// File: rtl/pwm_seq_dp.sv
`timescale 1ns/1ps
module pwm_seq_dp
  import pwm_seq_pkg::*;
#(
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chanEn,
  input  logic               tickIn,
  input  logic               wrValid,
  input  logic [7:0]         wrByte,
  input  logic [ADDR_W-1:0]  pc,
  input  ctlStb_t            stb,
  output logic [WORD_W-1:0]  instr,
  output logic [PTR_W-1:0]   progLen,
  output logic [PTR_W-1:0]   wrPtr,
  output logic [LVL_W-1:0]   levelQ,
  output logic               forceOnQ,
  output logic               forceOffQ,
  output logic               pwmOut
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic [WORD_W-1:0] progMem [DEPTH];
  logic [7:0]        hiByteQ;
  logic              hiValidQ;
  logic              enQ;
  logic [LVL_W-1:0]  pwmCntQ;
  logic              disEdge;
  logic              wordWr;

  assign disEdge = enQ && !chanEn;
  assign wordWr  = !disEdge && wrValid && !chanEn && hiValidQ && (wrPtr < DEPTH_P);

  // byte pairing and write address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      hiByteQ  <= '0;
      hiValidQ <= 1'b0;
      wrPtr    <= '0;
      progLen  <= '0;
    end else begin
      enQ <= chanEn;
      if (disEdge) begin
        wrPtr    <= '0;
        hiValidQ <= 1'b0;
      end else if (wrValid && !chanEn) begin
        if (!hiValidQ) begin
          hiByteQ  <= wrByte;
          hiValidQ <= 1'b1;
        end else begin
          hiValidQ <= 1'b0;
          if (wrPtr < DEPTH_P) begin
            wrPtr   <= wrPtr + 1'b1;
            progLen <= wrPtr + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wordWr) progMem[wrPtr[ADDR_W-1:0]] <= {hiByteQ, wrByte};
  end

  assign instr = progMem[pc];

  // duty level with saturation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
    end else if (stb.levelLoad) begin
      levelQ <= stb.loadVal;
    end else if (stb.stepUp && levelQ != '1) begin
      levelQ <= levelQ + 1'b1;
    end else if (stb.stepDn && levelQ != '0) begin
      levelQ <= levelQ - 1'b1;
    end
  end

  // forced states
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      forceOnQ  <= 1'b0;
      forceOffQ <= 1'b0;
    end else if (stb.forceClr) begin
      forceOnQ  <= 1'b0;
      forceOffQ <= 1'b0;
    end else begin
      if (stb.forceOff) forceOffQ <= 1'b1;
      if (stb.forceOn)  forceOnQ  <= 1'b1;
    end
  end

  // free-running compare counter and output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmCntQ <= '0;
      pwmOut  <= 1'b0;
    end else begin
      if (tickIn) pwmCntQ <= pwmCntQ + 1'b1;
      pwmOut <= chanEn && !forceOffQ && (forceOnQ || (levelQ >= pwmCntQ));
    end
  end
endmodule

// File: rtl/pwm_seq_ctrl.sv
`timescale 1ns/1ps
module pwm_seq_ctrl
  import pwm_seq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 512,
  parameter bit LOAD_EN  = 1'b1,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1,
  localparam int TCNT_W = $clog2(SLOW_DIV * 63 + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanEn,
  input  logic              tickIn,
  input  logic [WORD_W-1:0] instr,
  input  logic [PTR_W-1:0]  progLen,
  output logic [ADDR_W-1:0] pc,
  output ctlStb_t           stb
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RAMP, S_HALT} seqState_t;

  seqState_t         stateQ;
  logic [ADDR_W-1:0] pcQ;
  logic [6:0]        stepsLeftQ;
  logic              dirDnQ;
  logic [TCNT_W-1:0] tickCntQ;
  logic [TCNT_W-1:0] targetQ;

  instrKind_t        kind;
  logic              inRange;
  logic              stepDue;
  logic [5:0]        stEff;
  logic [TCNT_W-1:0] divSel;
  logic [TCNT_W-1:0] targetNew;

  assign kind      = classify(instr, LOAD_EN);
  assign inRange   = {1'b0, pcQ} < progLen;
  assign stEff     = (instr[13:8] == '0) ? 6'd1 : instr[13:8];
  assign divSel    = instr[14] ? TCNT_W'(SLOW_DIV) : TCNT_W'(FAST_DIV);
  assign targetNew = TCNT_W'(stEff) * divSel;
  assign stepDue   = (stateQ == S_RAMP) && tickIn && (tickCntQ == targetQ - 1'b1);
  assign pc        = pcQ;

  always_comb begin
    stb          = '0;
    stb.forceClr = !chanEn;
    stb.loadVal  = instr[LVL_W-1:0];
    if (chanEn && stateQ == S_FETCH && inRange) begin
      unique case (kind)
        K_OFF:   stb.forceOff  = 1'b1;
        K_ON:    stb.forceOn   = 1'b1;
        K_LOAD:  stb.levelLoad = 1'b1;
        default: ;
      endcase
    end
    if (chanEn && stepDue) begin
      stb.stepUp = !dirDnQ;
      stb.stepDn = dirDnQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= S_IDLE;
      pcQ        <= '0;
      stepsLeftQ <= '0;
      dirDnQ     <= 1'b0;
      tickCntQ   <= '0;
      targetQ    <= '0;
    end else if (!chanEn) begin
      stateQ <= S_IDLE;
      pcQ    <= '0;
    end else begin
      unique case (stateQ)
        S_IDLE: stateQ <= S_FETCH;
        S_FETCH: begin
          if (!inRange) begin
            pcQ <= '0;
          end else begin
            unique case (kind)
              K_GOTO: pcQ <= '0;
              K_OFF, K_ON: stateQ <= S_HALT;
              K_LOAD: pcQ <= pcQ + 1'b1;
              default: begin
                if (instr[6:0] == '0) begin
                  pcQ <= pcQ + 1'b1;
                end else begin
                  stepsLeftQ <= instr[6:0];
                  dirDnQ     <= instr[7];
                  targetQ    <= targetNew;
                  tickCntQ   <= '0;
                  stateQ     <= S_RAMP;
                end
              end
            endcase
          end
        end
        S_RAMP: begin
          if (tickIn) begin
            if (stepDue) begin
              tickCntQ   <= '0;
              stepsLeftQ <= stepsLeftQ - 1'b1;
              if (stepsLeftQ == 7'd1) begin
                pcQ    <= pcQ + 1'b1;
                stateQ <= S_FETCH;
              end
            end else begin
              tickCntQ <= tickCntQ + 1'b1;
            end
          end
        end
        default: stateQ <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/pwm_seq_chan.sv
`timescale 1ns/1ps
module pwm_seq_chan
  import pwm_seq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 512,
  parameter bit LOAD_EN  = 1'b1,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanEn,
  input  logic       tickIn,
  input  logic       wrValid,
  input  logic [7:0] wrByte,
  output logic       pwmOut,
  output logic [7:0] levelOut
);
  logic [WORD_W-1:0] instr;
  logic [PTR_W-1:0]  progLen;
  logic [PTR_W-1:0]  wrPtr;
  logic [ADDR_W-1:0] pc;
  logic              forceOnQ;
  logic              forceOffQ;
  ctlStb_t           ctlStb;

  pwm_seq_ctrl #(
    .DEPTH(DEPTH), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .LOAD_EN(LOAD_EN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .tickIn(tickIn),
    .instr(instr), .progLen(progLen), .pc(pc), .stb(ctlStb)
  );

  pwm_seq_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .tickIn(tickIn),
    .wrValid(wrValid), .wrByte(wrByte), .pc(pc), .stb(ctlStb),
    .instr(instr), .progLen(progLen), .wrPtr(wrPtr), .levelQ(levelOut),
    .forceOnQ(forceOnQ), .forceOffQ(forceOffQ), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_seq_chk.sv
`timescale 1ns/1ps
module pwm_seq_chk
  import pwm_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             chanEn,
  input logic             tickIn,
  input logic             pwmOut,
  input logic [7:0]       levelOut,
  input logic [PTR_W-1:0] wrPtr,
  input logic             forceOn,
  input logic             forceOff,
  input ctlStb_t          stb
);
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> !pwmOut); // R2
  AST_DISABLED_KEEP_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> $stable(levelOut)); // R2
  AST_NO_WRITE_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    chanEn |=> $stable(wrPtr)); // R1
  AST_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= PTR_W'(DEPTH)); // R1
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    forceOn && !forceOff && chanEn |=> pwmOut); // R4
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    forceOff |=> !pwmOut); // R4
  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tickIn && !stb.levelLoad |=> $stable(levelOut)); // R7
  AST_ONE_LEVEL_OP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.levelLoad, stb.stepUp, stb.stepDn})); // R6
endmodule

bind pwm_seq_chan pwm_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .chanEn(chanEn), .tickIn(tickIn),
  .pwmOut(pwmOut), .levelOut(levelOut), .wrPtr(wrPtr),
  .forceOn(forceOnQ), .forceOff(forceOffQ), .stb(ctlStb)
);

// File: tb/pwm_seq_chan_tb_top.sv
`timescale 1ns/1ps
module pwm_seq_chan_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chanEn = 1'b0;
  logic       tickIn = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrByte = '0;
  logic       pwmOut;
  logic [7:0] levelOut;

  int total = 0;
  int bad = 0;
  logic [7:0]  cntModel = '0;
  logic [15:0] progBuf [64];
  int progN = 0;

  always #4 clk = ~clk;

  pwm_seq_chan dut_i (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .tickIn(tickIn),
    .wrValid(wrValid), .wrByte(wrByte), .pwmOut(pwmOut), .levelOut(levelOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tickOnce();
    tickIn = 1'b1;
    @(negedge clk);
    tickIn = 1'b0;
    cntModel = cntModel + 8'd1;
    @(negedge clk);
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) tickOnce();
  endtask

  task automatic writeWord(input logic [15:0] w);
    wrValid = 1'b1;
    wrByte  = w[15:8];
    @(negedge clk);
    wrByte  = w[7:0];
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic loadProg();
    chanEn = 1'b0;
    idle(2);
    for (int i = 0; i < progN; i++) writeWord(progBuf[i]);
    idle(1);
  endtask

  task automatic startRun();
    chanEn = 1'b1;
    idle(4);
  endtask

  function automatic int satMove(input int s, input int n, input bit down);
    int r;
    r = down ? s - n : s + n;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  function automatic logic [15:0] ldWord(input logic [7:0] v);
    return {8'h40, v};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(3);
    rstN = 1'b1;
    idle(2);
    chk("R3 reset pwmOut", int'(pwmOut), 0);
    chk("R3 reset level", int'(levelOut), 0);

    // R6 + R3: random direct loads compared against counter model
    for (int it = 0; it < 8; it++) begin
      logic [7:0] v;
      int nt;
      v = (it == 0) ? 8'hFF : 8'($urandom);
      progBuf[0] = ldWord(v); progN = 1;
      loadProg();
      startRun();
      chk("R6 load level", int'(levelOut), int'(v));
      nt = 1 + int'($urandom % 40);
      for (int k = 0; k < nt; k++) begin
        tickOnce();
        chk("R3 compare", int'(pwmOut), int'(v >= cntModel));
      end
    end

    // R7/R8: random fast ramps ending in forced-off halt
    for (int it = 0; it < 10; it++) begin
      int s, n, st;
      bit dn;
      s  = int'($urandom % 256);
      n  = 1 + int'($urandom % 20);
      st = 1 + int'($urandom % 2);
      dn = 1'($urandom);
      progBuf[0] = ldWord(8'(s));
      progBuf[1] = {2'b00, 6'(st), dn, 7'(n)};
      progBuf[2] = 16'h007F;
      progN = 3;
      loadProg();
      startRun();
      runTicks(n * st * 16 - 1);
      chk("R8 before last step", int'(levelOut), satMove(s, n - 1, dn));
      tickOnce();
      idle(3);
      chk("R7 ramp end level", int'(levelOut), satMove(s, n, dn));
      chk("R4 halt off", int'(pwmOut), 0);
    end

    // R7 saturation both ends
    progBuf[0] = ldWord(8'hFA); progBuf[1] = 16'h010A; progBuf[2] = 16'h007F; progN = 3;
    loadProg(); startRun(); runTicks(160); idle(2);
    chk("R7 saturate high", int'(levelOut), 255);
    progBuf[0] = ldWord(8'd3); progBuf[1] = 16'h018A; progN = 3;
    loadProg(); startRun(); runTicks(160); idle(2);
    chk("R7 saturate low", int'(levelOut), 0);

    // R7 zero-step ramp moves on
    progBuf[0] = ldWord(8'd9); progBuf[1] = 16'h0100; progBuf[2] = 16'h00FF; progN = 3;
    loadProg(); startRun(); idle(2);
    chk("R7 zero steps", int'(pwmOut), 1);

    // R8 prescaled step
    progBuf[0] = ldWord(8'd50); progBuf[1] = 16'h4101; progBuf[2] = 16'h007F; progN = 3;
    loadProg(); startRun(); runTicks(511);
    chk("R8 slow before", int'(levelOut), 50);
    tickOnce();
    chk("R8 slow after", int'(levelOut), 51);

    // R8 step time 3 and step time 0
    progBuf[0] = ldWord(8'd100); progBuf[1] = 16'h0302; progN = 3;
    loadProg(); startRun(); runTicks(47);
    chk("R8 st3 before", int'(levelOut), 100);
    tickOnce();
    chk("R8 st3 first", int'(levelOut), 101);
    runTicks(48);
    chk("R8 st3 second", int'(levelOut), 102);
    progBuf[0] = ldWord(8'd60); progBuf[1] = 16'h0001; progN = 3;
    loadProg(); startRun(); runTicks(15);
    chk("R8 st0 before", int'(levelOut), 60);
    tickOnce();
    chk("R8 st0 after", int'(levelOut), 61);

    // R5 branch and goto-start
    progBuf[0] = ldWord(8'd10); progBuf[1] = 16'hA000; progBuf[2] = ldWord(8'd99); progN = 3;
    loadProg(); startRun(); idle(20);
    chk("R5 branch", int'(levelOut), 10);
    progBuf[0] = ldWord(8'd20); progBuf[1] = 16'h0000; progBuf[2] = ldWord(8'd99); progN = 3;
    loadProg(); startRun(); idle(20);
    chk("R5 goto start", int'(levelOut), 20);

    // R9 run off end
    progBuf[0] = ldWord(8'd30); progBuf[1] = 16'h0102; progN = 2;
    loadProg(); startRun(); runTicks(32); idle(3);
    chk("R9 wrap reload", int'(levelOut), 30);
    runTicks(16);
    chk("R9 wrap rerun", int'(levelOut), 31);

    // R4 forced high and low
    progBuf[0] = ldWord(8'd0); progBuf[1] = 16'h00FF; progN = 2;
    loadProg(); startRun();
    for (int k = 0; k < 20; k++) begin
      tickOnce();
      chk("R4 forced high", int'(pwmOut), 1);
    end
    progBuf[0] = ldWord(8'hFF); progBuf[1] = 16'h007F; progN = 2;
    loadProg(); startRun();
    for (int k = 0; k < 20; k++) begin
      tickOnce();
      chk("R4 forced low", int'(pwmOut), 0);
    end

    // R2 disable parks low, keeps level
    progBuf[0] = ldWord(8'hFF); progN = 1;
    loadProg(); startRun(); tickOnce();
    chk("R2 running high", int'(pwmOut), 1);
    chanEn = 1'b0;
    idle(2);
    chk("R2 disabled low", int'(pwmOut), 0);
    chk("R2 level kept", int'(levelOut), 255);
    runTicks(5);
    chk("R2 stays low", int'(pwmOut), 0);

    // R1 writes ignored while running
    progBuf[0] = ldWord(8'd40); progN = 1;
    loadProg(); startRun();
    writeWord(ldWord(8'd77));
    idle(4);
    chk("R1 ignored while running", int'(levelOut), 40);
    chanEn = 1'b0; idle(2); startRun();
    chk("R1 program unchanged", int'(levelOut), 40);

    // R1/R2 write address restarts after disable
    progBuf[0] = ldWord(8'd5); progBuf[1] = ldWord(8'd6); progN = 2;
    loadProg(); startRun();
    progBuf[0] = ldWord(8'd7); progN = 1;
    loadProg(); startRun();
    chk("R1 reload first", int'(levelOut), 7);
    idle(3);
    chk("R1 reload stable", int'(levelOut), 7);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule